// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block lets the two ports of a shared 1K x 8 memory signal each other. The two highest addresses of the array act as mailboxes. The next-to-top word belongs to port A (the left port) and the top word belongs to port B (the right port). When one port writes into its partner's mailbox, the partner's active-low interrupt goes low. The partner clears that interrupt by reading its own mailbox with chip select and output enable both low.

The block only watches each port's address, chip select, write strobe, output enable and busy input. It reacts on the rising clock edge, and each flag lives in one register. The mailbox bytes stay in the ordinary array and are never read or decoded here. When the feature parameter is off, both interrupt outputs stay high, and the two top words act as plain storage.

Top module: `mbx_irq`

## Requirements
- R1: While reset is low, and after reset is released, both `a_irq_n` and `b_irq_n` are 1 (deasserted).
- R2: A cycle in which port B has `b_cs_n`=0, `b_we_n`=0, `b_busy_n`=1 and `b_addr` = 2^ADDR_W-2 (0x3FE by default) drives `a_irq_n` to 0 after that clock edge.
- R3: A cycle in which port A has `a_cs_n`=0, `a_we_n`=0, `a_busy_n`=1 and `a_addr` = 2^ADDR_W-1 (0x3FF) drives `b_irq_n` to 0 after that clock edge.
- R4: A cycle in which port A has `a_cs_n`=0, `a_oe_n`=0, `a_busy_n`=1 and `a_addr` = 0x3FE returns `a_irq_n` to 1, whatever the value of `a_we_n`, provided no set of that flag happens in the same cycle.
- R5: A cycle in which port B has `b_cs_n`=0, `b_oe_n`=0, `b_busy_n`=1 and `b_addr` = 0x3FF returns `b_irq_n` to 1, whatever the value of `b_we_n`, provided no set of that flag happens in the same cycle.
- R6: When the writing port's busy input is 0, its write to the partner's mailbox leaves the partner's interrupt unchanged.
- R7: When the reading port's busy input is 0, its read of its own mailbox leaves its interrupt unchanged.
- R8: If a set and a clear of the same flag happen in the same cycle, the flag ends up asserted (0).
- R9: None of the following changes either interrupt: accesses to other addresses, accesses with chip select high, a port's write to its own mailbox, and a port's read of its partner's mailbox.
- R10: With IRQ_EN=0, both interrupt outputs are 1 under every input pattern.
- R11: A flag with no set and no clear in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all flag updates happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | ADDR_W | Port A address |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_busy_n | input | 1 | Port A busy from arbitration, active low; blocks port A actions |
| b_addr | input | ADDR_W | Port B address |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_busy_n | input | 1 | Port B busy from arbitration, active low; blocks port B actions |
| a_irq_n | output | 1 | Interrupt toward port A, active low |
| b_irq_n | output | 1 | Interrupt toward port B, active low |

## Verification
The assertions check, on every cycle, the rules that involve a single flag. A set always lands and wins over a clear. A clear without a set empties the flag. A flag without events holds its value. A busy acting port can neither raise nor drop the flag it would touch. Address decoding can only be shown by the bench scenarios: the exact mailbox word, which port owns which word, the chip-select qualification, the write-strobe indifference of a clear, and the disabled variant.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Raw strobe decode of one port, before busy gating
  typedef struct packed {
    logic wr;   // selected write
    logic rd;   // selected, output-enabled access
  } acc_t;

  // Mailbox word owned by a side: side 0 -> top-1, side 1 -> top
  function automatic int unsigned mbx_slot(int unsigned aw, bit side);
    return (32'd1 << aw) - 32'd2 + {31'd0, side};
  endfunction

  function automatic acc_t mbx_classify(logic cs_n, logic we_n, logic oe_n);
    acc_t a;
    a.wr = !cs_n && !we_n;
    a.rd = !cs_n && !oe_n;
    return a;
  endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int unsigned AW   = 10,
  parameter bit          SIDE = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          busy_n,
  output logic          ring_o,   // raises the partner's flag
  output logic          ack_o     // clears this side's flag
);
  localparam int unsigned OWN_I  = mbx_slot(AW, SIDE);
  localparam int unsigned PEER_I = mbx_slot(AW, !SIDE);
  localparam logic [AW-1:0] OWN_SLOT  = AW'(OWN_I);
  localparam logic [AW-1:0] PEER_SLOT = AW'(PEER_I);

  acc_t acc;
  logic own_hit;
  logic peer_hit;

  assign acc      = mbx_classify(cs_n, we_n, oe_n);
  assign own_hit  = (addr == OWN_SLOT);
  assign peer_hit = (addr == PEER_SLOT);

  assign ring_o = busy_n && acc.wr && peer_hit;
  assign ack_o  = busy_n && acc.rd && own_hit;
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;   // set wins over a same-cycle clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o) else $error("set lost"); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o) else $error("clear lost"); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o)) else $error("flag drift"); // R11
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int unsigned ADDR_W = 10,
  parameter bit          IRQ_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic              a_busy_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic              b_busy_n,
  output logic              a_irq_n,
  output logic              b_irq_n
);
  generate
    if (IRQ_EN) begin : g_on
      logic a_ring, a_ack, b_ring, b_ack;
      logic a_flag, b_flag;

      mbx_port_dec #(.AW(ADDR_W), .SIDE(1'b0)) u_dec_a (
        .addr(a_addr), .cs_n(a_cs_n), .we_n(a_we_n), .oe_n(a_oe_n),
        .busy_n(a_busy_n), .ring_o(a_ring), .ack_o(a_ack));
      mbx_port_dec #(.AW(ADDR_W), .SIDE(1'b1)) u_dec_b (
        .addr(b_addr), .cs_n(b_cs_n), .we_n(b_we_n), .oe_n(b_oe_n),
        .busy_n(b_busy_n), .ring_o(b_ring), .ack_o(b_ack));

      mbx_flag u_flag_a (.clk(clk), .rst_n(rst_n),
        .set_i(b_ring), .clr_i(a_ack), .flag_o(a_flag));
      mbx_flag u_flag_b (.clk(clk), .rst_n(rst_n),
        .set_i(a_ring), .clr_i(b_ack), .flag_o(b_flag));

      assign a_irq_n = !a_flag;
      assign b_irq_n = !b_flag;

      AST_BUSY_NO_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_busy_n && a_irq_n) |=> a_irq_n) else $error("busy set A"); // R6
      AST_BUSY_NO_SET_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_busy_n && b_irq_n) |=> b_irq_n) else $error("busy set B"); // R6
      AST_BUSY_NO_CLR_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_busy_n && !a_irq_n) |=> !a_irq_n) else $error("busy clr A"); // R7
      AST_BUSY_NO_CLR_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_busy_n && !b_irq_n) |=> !b_irq_n) else $error("busy clr B"); // R7
    end else begin : g_off
      assign a_irq_n = 1'b1;
      assign b_irq_n = 1'b1;
    end
  endgenerate
endmodule

// File: tb/mbx_irq_bench.sv
module mbx_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // ctl nibble = {cs_n, we_n, oe_n, busy_n}
  // fields: a_addr(10) a_ctl(4) b_addr(10) b_ctl(4) exp_a exp_b req(4)
  localparam logic [33:0] VECS [0:NV-1] = '{
    {10'h000, 4'b1111, 10'h000, 4'b1111, 1'b1, 1'b1, 4'd11}, // R11 idle
    {10'h3FF, 4'b0011, 10'h000, 4'b1111, 1'b1, 1'b0, 4'd3},  // R3
    {10'h000, 4'b1111, 10'h000, 4'b1111, 1'b1, 1'b0, 4'd11}, // R11 hold
    {10'h000, 4'b1111, 10'h3FE, 4'b0010, 1'b1, 1'b0, 4'd6},  // R6 busy write
    {10'h000, 4'b1111, 10'h3FE, 4'b0011, 1'b0, 1'b0, 4'd2},  // R2
    {10'h3FE, 4'b0100, 10'h000, 4'b1111, 1'b0, 1'b0, 4'd7},  // R7 busy read
    {10'h3FE, 4'b0101, 10'h000, 4'b1111, 1'b1, 1'b0, 4'd4},  // R4
    {10'h000, 4'b1111, 10'h3FF, 4'b0001, 1'b1, 1'b1, 4'd5},  // R5 we low too
    {10'h3FE, 4'b0011, 10'h000, 4'b1111, 1'b1, 1'b1, 4'd9},  // R9 own write
    {10'h000, 4'b1111, 10'h3FF, 4'b0011, 1'b1, 1'b1, 4'd9},  // R9 own write
    {10'h100, 4'b0011, 10'h000, 4'b0011, 1'b1, 1'b1, 4'd9},  // R9 other addr
    {10'h3FF, 4'b1011, 10'h3FE, 4'b1011, 1'b1, 1'b1, 4'd9},  // R9 cs high
    {10'h3FF, 4'b0011, 10'h3FF, 4'b0101, 1'b1, 1'b0, 4'd8},  // R8 B set+clr
    {10'h3FE, 4'b0101, 10'h3FE, 4'b0011, 1'b0, 1'b0, 4'd8},  // R8 A set+clr
    {10'h3FF, 4'b0101, 10'h3FE, 4'b0101, 1'b0, 1'b0, 4'd9},  // R9 peer read
    {10'h3FE, 4'b0101, 10'h3FF, 4'b0101, 1'b1, 1'b1, 4'd4}   // R4 R5 both clear
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] a_addr = '0, b_addr = '0;
  logic a_cs_n = 1'b1, a_we_n = 1'b1, a_oe_n = 1'b1, a_busy_n = 1'b1;
  logic b_cs_n = 1'b1, b_we_n = 1'b1, b_oe_n = 1'b1, b_busy_n = 1'b1;
  logic a_irq_n, b_irq_n, a_off_n, b_off_n;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  mbx_irq u_mbx_irq (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_busy_n(a_busy_n),
    .b_addr(b_addr), .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_busy_n(b_busy_n),
    .a_irq_n(a_irq_n), .b_irq_n(b_irq_n));

  mbx_irq #(.IRQ_EN(1'b0)) u_mbx_irq_off (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_busy_n(a_busy_n),
    .b_addr(b_addr), .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_busy_n(b_busy_n),
    .a_irq_n(a_off_n), .b_irq_n(b_off_n));

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [9:0] aa, logic [3:0] ac, logic [9:0] ba, logic [3:0] bc);
    a_addr = aa; {a_cs_n, a_we_n, a_oe_n, a_busy_n} = ac;
    b_addr = ba; {b_cs_n, b_we_n, b_oe_n, b_busy_n} = bc;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1", "a_irq_n in reset", a_irq_n, 1'b1);
    chk("R1", "b_irq_n in reset", b_irq_n, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "a_irq_n after reset", a_irq_n, 1'b1);
    chk("R1", "b_irq_n after reset", b_irq_n, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      string rq;
      v = VECS[i];
      @(negedge clk) drive(v[33:24], v[23:20], v[19:10], v[9:6]);
      @(posedge clk); #1;
      rq = $sformatf("R%0d", v[3:0]);
      chk(rq, $sformatf("vec %0d a_irq_n", i), a_irq_n, v[5]);
      chk(rq, $sformatf("vec %0d b_irq_n", i), b_irq_n, v[4]);
      chk("R10", $sformatf("vec %0d disabled outs", i), a_off_n & b_off_n, 1'b1);
    end

    // raise both, then reset asynchronously: R1
    @(negedge clk) drive(10'h3FF, 4'b0011, 10'h3FE, 4'b0011);
    @(posedge clk); #1;
    chk("R2", "a_irq_n before reset", a_irq_n, 1'b0);
    chk("R3", "b_irq_n before reset", b_irq_n, 1'b0);
    chk("R10", "disabled outs during sets", a_off_n & b_off_n, 1'b1);
    @(negedge clk) drive(10'h000, 4'b1111, 10'h000, 4'b1111);
    rst_n = 1'b0;
    #1;
    chk("R1", "a_irq_n on async reset", a_irq_n, 1'b1);
    chk("R1", "b_irq_n on async reset", b_irq_n, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R11", "a_irq_n idle after reset", a_irq_n, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule